// File: doc/BRIEF.md
# Quad Wiper Position Counter with Tap Decode

This block keeps the wiper setting of four digitally controlled potentiometers. Each pot owns one 6-bit volatile position counter. The counter can change in four ways:

- the host writes a new value directly;
- a neighbouring data-register block loads a stored value in parallel, either into one pot or into all pots at once;
- a step pulse moves it one tap up or down;
- a power-up recall copies in each pot's first stored setting (data register 0).

Every position drives a registered 64-way one-hot tap select for the resistor-array switches, so exactly one switch is closed at all times. A combinational readback port returns the position of any selected pot for the serial interface.

When several sources hit the same pot in one cycle, a fixed priority decides which one wins. A recall beats everything. A direct write beats a parallel load. Any load beats a step.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every position becomes 0 and every tap select becomes value 1 (only bit 0 set).
- R2: `wr_en` with `wr_pot` = p sets position p to `wr_val` at the next edge and leaves the other positions unchanged.
- R3: Each bit p of `ld_mask` loads position p from slice p of `ld_val` (bits 6p+5..6p). All bits set performs the global transfer in one cycle.
- R4: `step_up` or `step_down` alone, with `step_pot` = p, moves position p by +1 or -1 at the next edge.
- R5: Stepping saturates. Up at 63 stays at 63, and down at 0 stays at 0.
- R6: `step_up` and `step_down` asserted together leave the position unchanged. With no strobe, every position holds.
- R7: `recall_req` loads every position p from slice p of `recall_val`. It overrides any write, load or step in the same cycle.
- R8: On one pot in one cycle, a direct write beats a parallel load, and a parallel load beats a step.
- R9: Each pot's 64-bit tap select always has exactly one bit set. Its bit index equals that pot's position one clock earlier.
- R10: Position 0 selects tap bit 0, which is the low terminal. Position 63 selects tap bit 63, which is the high terminal.
- R11: `rd_val` combinationally equals the current position of the pot chosen by `rd_pot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recall_req | input | 1 | Power-up recall strobe |
| recall_val | input | 24 | Data register 0 contents, 6 bits per pot, pot 0 in the low bits |
| wr_en | input | 1 | Direct write strobe |
| wr_pot | input | 2 | Pot targeted by the write |
| wr_val | input | 6 | Direct write value |
| ld_mask | input | 4 | Per-pot parallel load enables |
| ld_val | input | 24 | Parallel load values, 6 bits per pot |
| step_up | input | 1 | Step one tap toward the high terminal |
| step_down | input | 1 | Step one tap toward the low terminal |
| step_pot | input | 2 | Pot targeted by a step |
| rd_pot | input | 2 | Pot selected for readback |
| rd_val | output | 6 | Readback position |
| pos_o | output | 24 | All four positions, pot 0 in the low bits |
| tap_o | output | 256 | Four 64-bit one-hot tap selects, pot 0 in the low bits |

## Verification
The bench drives conflicting sources into one pot in the same cycle: recall together with a write, a load and a step, then a write together with a load, then a load together with a step. A design with its priority order swapped would keep the wrong value.

It also steps past both ends of the range. A design that wraps would jump from 63 to 0 or from 0 to 63.

It pulses up and down together. A design that favours one direction would move the wiper.

Because the tap select is registered, it is compared against the model's position from the previous cycle. A design that decodes combinationally, or decodes the new position too early, would land one cycle off. A design that ever shows zero or two taps would break the exactly-one rule.

// File: rtl/wiper_pkg.sv
// Shared definitions for the wiper position bank.
// Assumes: the caller supplies one-bit strobes already qualified per pot.
package wiper_pkg;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_RECALL,
        UPD_WRITE,
        UPD_LOAD,
        UPD_UP,
        UPD_DOWN
    } upd_src_e;

    // Fixed priority: recall, write, load, then a single-direction step.
    function automatic upd_src_e pick_src(input logic recall, input logic wr,
                                          input logic ld, input logic up,
                                          input logic dn);
        if (recall)          return UPD_RECALL;
        else if (wr)         return UPD_WRITE;
        else if (ld)         return UPD_LOAD;
        else if (up && !dn)  return UPD_UP;
        else if (dn && !up)  return UPD_DOWN;
        else                 return UPD_HOLD;
    endfunction

endpackage

// File: rtl/wiper_cell.sv
// One pot's position counter: picks one update source per cycle by fixed
// priority and holds the result. Steps saturate at both ends.
// Assumes: strobes are already decoded to this pot by the caller.
module wiper_cell
    import wiper_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             recall_i,
    input  logic [POS_W-1:0] recall_val_i,
    input  logic             wr_hit_i,
    input  logic [POS_W-1:0] wr_val_i,
    input  logic             ld_hit_i,
    input  logic [POS_W-1:0] ld_val_i,
    input  logic             up_hit_i,
    input  logic             dn_hit_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    upd_src_e         src;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;

    // Select the winning source for this cycle.
    always_comb src = pick_src(recall_i, wr_hit_i, ld_hit_i, up_hit_i, dn_hit_i);

    // Form the next position, clamping steps at the range ends.
    always_comb begin
        pos_d = pos_q;
        unique case (src)
            UPD_RECALL: pos_d = recall_val_i;
            UPD_WRITE:  pos_d = wr_val_i;
            UPD_LOAD:   pos_d = ld_val_i;
            UPD_UP:     pos_d = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
            UPD_DOWN:   pos_d = (pos_q == POS_MIN) ? pos_q : pos_q - 1'b1;
            default:    pos_d = pos_q;
        endcase
    end

    // Position register with synchronous reset to the low terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos_o = pos_q;

    // R7
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_i |=> pos_o == $past(recall_val_i));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && wr_hit_i) |=> pos_o == $past(wr_val_i));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && !wr_hit_i && ld_hit_i) |=> pos_o == $past(ld_val_i));

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && !wr_hit_i && !ld_hit_i && up_hit_i && !dn_hit_i && pos_o != POS_MAX)
        |=> pos_o == $past(pos_o) + 1'b1);

    // R5
    up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && !wr_hit_i && !ld_hit_i && up_hit_i && !dn_hit_i && pos_o == POS_MAX)
        |=> pos_o == POS_MAX);

    // R5
    down_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && !wr_hit_i && !ld_hit_i && dn_hit_i && !up_hit_i && pos_o == POS_MIN)
        |=> pos_o == POS_MIN);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall_i && !wr_hit_i && !ld_hit_i && (up_hit_i == dn_hit_i)) |=> $stable(pos_o));

endmodule

// File: rtl/tap_decoder.sv
// Registered one-hot decode of a position into its tap-switch select.
// The register keeps decode glitches off the switch drivers.
// Assumes: the position input is a registered value.
module tap_decoder #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);
    logic [TAPS-1:0] tap_q;

    // Decode and register; reset closes only the low-terminal switch.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= TAPS'(1);
        else        tap_q <= TAPS'(1) << pos_i;
    end

    assign tap_o = tap_q;

    // R9
    one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);

    // R9
    tap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_o[$past(pos_i)]);

    // R10
    high_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i == {POS_W{1'b1}}) |=> tap_o[TAPS-1]);

endmodule

// File: rtl/pos_readback.sv
// Combinational readback mux: returns the position of the selected pot.
// Assumes: positions are packed with pot 0 in the low bits.
module pos_readback #(
    parameter int NUM_POTS = 4,
    parameter int POS_W    = 6,
    parameter int SEL_W    = $clog2(NUM_POTS)
) (
    input  logic [NUM_POTS*POS_W-1:0] pos_i,
    input  logic [SEL_W-1:0]          sel_i,
    output logic [POS_W-1:0]          val_o
);
    // Pick the slice whose index matches the select.
    always_comb begin
        val_o = '0;
        for (int p = 0; p < NUM_POTS; p++) begin
            if (sel_i == SEL_W'(p)) val_o = pos_i[p*POS_W +: POS_W];
        end
    end

    // R11
    readback_chk: assert final (val_o == pos_i[sel_i*POS_W +: POS_W] || $isunknown(sel_i));

endmodule

// File: rtl/wiper_bank.sv
// Bank of wiper position counters, one per pot, each with its own
// registered tap decode, plus a readback mux.
// Assumes: the caller supplies data-register contents on recall_val and ld_val.
module wiper_bank #(
    parameter int NUM_POTS = 4,
    parameter int POS_W    = 6,
    parameter int SEL_W    = $clog2(NUM_POTS),
    parameter int TAPS     = 1 << POS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recall_req,
    input  logic [NUM_POTS*POS_W-1:0] recall_val,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_pot,
    input  logic [POS_W-1:0]          wr_val,
    input  logic [NUM_POTS-1:0]       ld_mask,
    input  logic [NUM_POTS*POS_W-1:0] ld_val,
    input  logic                      step_up,
    input  logic                      step_down,
    input  logic [SEL_W-1:0]          step_pot,
    input  logic [SEL_W-1:0]          rd_pot,
    output logic [POS_W-1:0]          rd_val,
    output logic [NUM_POTS*POS_W-1:0] pos_o,
    output logic [NUM_POTS*TAPS-1:0]  tap_o
);
    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        logic wr_hit;
        logic up_hit;
        logic dn_hit;

        // Qualify the shared strobes for this pot.
        always_comb begin
            wr_hit = wr_en     && (wr_pot   == SEL_W'(p));
            up_hit = step_up   && (step_pot == SEL_W'(p));
            dn_hit = step_down && (step_pot == SEL_W'(p));
        end

        wiper_cell #(.POS_W(POS_W)) u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .recall_i     (recall_req),
            .recall_val_i (recall_val[p*POS_W +: POS_W]),
            .wr_hit_i     (wr_hit),
            .wr_val_i     (wr_val),
            .ld_hit_i     (ld_mask[p]),
            .ld_val_i     (ld_val[p*POS_W +: POS_W]),
            .up_hit_i     (up_hit),
            .dn_hit_i     (dn_hit),
            .pos_o        (pos_o[p*POS_W +: POS_W])
        );

        tap_decoder #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .pos_i (pos_o[p*POS_W +: POS_W]),
            .tap_o (tap_o[p*TAPS +: TAPS])
        );
    end

    pos_readback #(.NUM_POTS(NUM_POTS), .POS_W(POS_W), .SEL_W(SEL_W)) u_rd (
        .pos_i (pos_o),
        .sel_i (rd_pot),
        .val_o (rd_val)
    );

    // R2
    write_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !recall_req && ld_mask == '0 && !step_up && !step_down && wr_pot != '0)
        |=> $stable(pos_o[POS_W-1:0]));

endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int W  = 6;
    localparam int T  = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            recall_req = 1'b0;
    logic [NP*W-1:0] recall_val = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_pot = '0;
    logic [W-1:0]    wr_val = '0;
    logic [NP-1:0]   ld_mask = '0;
    logic [NP*W-1:0] ld_val = '0;
    logic            step_up = 1'b0;
    logic            step_down = 1'b0;
    logic [1:0]      step_pot = '0;
    logic [1:0]      rd_pot = '0;
    logic [W-1:0]    rd_val;
    logic [NP*W-1:0] pos_o;
    logic [NP*T-1:0] tap_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    m_pos [NP];
    int    m_tap [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_bank u_dut (
        .clk(clk), .rst_n(rst_n), .recall_req(recall_req), .recall_val(recall_val),
        .wr_en(wr_en), .wr_pot(wr_pot), .wr_val(wr_val), .ld_mask(ld_mask),
        .ld_val(ld_val), .step_up(step_up), .step_down(step_down),
        .step_pot(step_pot), .rd_pot(rd_pot), .rd_val(rd_val),
        .pos_o(pos_o), .tap_o(tap_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge.
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            m_tap[p] = m_pos[p];
            if (!rst_n) begin
                m_pos[p] = 0;
                m_tap[p] = 0;
            end else if (recall_req)
                m_pos[p] = int'(recall_val[p*W +: W]);
            else if (wr_en && wr_pot == 2'(p))
                m_pos[p] = int'(wr_val);
            else if (ld_mask[p])
                m_pos[p] = int'(ld_val[p*W +: W]);
            else if (step_up && !step_down && step_pot == 2'(p))
                m_pos[p] = (m_pos[p] == 63) ? 63 : m_pos[p] + 1;
            else if (step_down && !step_up && step_pot == 2'(p))
                m_pos[p] = (m_pos[p] == 0) ? 0 : m_pos[p] - 1;
        end
    end

    // Compare every output against the model on the falling edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int p = 0; p < NP; p++) begin
                chk(cur_req, 64'(pos_o[p*W +: W]), 64'(m_pos[p]));
                chk("R9", tap_o[p*T +: T], 64'd1 << m_tap[p]);
            end
            chk("R11", 64'(rd_val), 64'(m_pos[rd_pot]));
        end
    end

    // Advance to the next drive point and drop all strobes.
    task automatic nxt();
        @(negedge clk);
        #2;
        recall_req = 0; wr_en = 0; ld_mask = '0; step_up = 0; step_down = 0;
    endtask

    task automatic do_write(input int p, input int v);
        wr_en = 1; wr_pot = 2'(p); wr_val = W'(v); rd_pot = 2'(p);
        nxt();
    endtask

    task automatic do_step(input int p, input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            step_pot = 2'(p); step_up = up; step_down = !up;
            nxt();
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin m_pos[p] = 0; m_tap[p] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset values seen while reset is held
        for (int p = 0; p < NP; p++) begin
            chk("R1", 64'(pos_o[p*W +: W]), 64'd0);
            chk("R1", tap_o[p*T +: T], 64'd1);
        end
        #2;
        cmp_en = 1;
        rst_n = 1;
        nxt();

        cur_req = "R2";
        do_write(0, 5); do_write(1, 17); do_write(2, 40); do_write(3, 63);
        nxt();

        cur_req = "R3";
        ld_mask = 4'b0100; ld_val = {6'd1, 6'd2, 6'd3, 6'd4};
        nxt();
        ld_mask = 4'b1111; ld_val = {6'd50, 6'd33, 6'd20, 6'd9};
        nxt();

        cur_req = "R4";
        do_step(1, 1'b1, 3);
        do_step(2, 1'b0, 2);

        cur_req = "R5";
        do_write(0, 62);
        do_step(0, 1'b1, 3);
        do_write(3, 1);
        do_step(3, 1'b0, 3);
        chk("R5", 64'(pos_o[0 +: W]), 64'd63);
        chk("R5", 64'(pos_o[3*W +: W]), 64'd0);

        cur_req = "R6";
        step_pot = 2'd1; step_up = 1; step_down = 1;
        nxt();
        nxt();

        cur_req = "R10";
        nxt();
        chk("R10", 64'(tap_o[T-1]), 64'd1);
        chk("R10", 64'(tap_o[3*T]), 64'd1);

        cur_req = "R7";
        recall_val = {6'd11, 6'd22, 6'd33, 6'd44};
        recall_req = 1; wr_en = 1; wr_pot = 2'd2; wr_val = 6'd7;
        ld_mask = 4'b1111; step_up = 1; step_pot = 2'd0;
        nxt();
        chk("R7", 64'(pos_o[2*W +: W]), 64'd22);

        cur_req = "R8";
        wr_en = 1; wr_pot = 2'd1; wr_val = 6'd12; ld_mask = 4'b0010;
        ld_val = '0; step_up = 1; step_pot = 2'd1;
        nxt();
        chk("R8", 64'(pos_o[W +: W]), 64'd12);
        ld_mask = 4'b0001; ld_val = {18'd0, 6'd30}; step_down = 1; step_pot = 2'd0;
        nxt();
        chk("R8", 64'(pos_o[0 +: W]), 64'd30);

        // R8: randomised mix of all sources, every cycle checked.
        for (int i = 0; i < 400; i++) begin
            rd_pot     = 2'($urandom_range(0, 3));
            recall_req = ($urandom_range(0, 31) == 0);
            recall_val = 24'($urandom);
            wr_en      = ($urandom_range(0, 3) == 0);
            wr_pot     = 2'($urandom_range(0, 3));
            wr_val     = 6'($urandom);
            ld_mask    = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
            ld_val     = 24'($urandom);
            step_up    = ($urandom_range(0, 1) == 1);
            step_down  = ($urandom_range(0, 2) == 0);
            step_pot   = 2'($urandom_range(0, 3));
            nxt();
        end

        nxt();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule